// File: doc/BRIEF.md
# Two-Wire Serial Read-Only Memory Slave

This block is the slave end of a two-wire serial bus (a clock line and an open-drain data line) sitting in front of a 128-byte register file. The master can read bytes in three ways. A current-address read returns the byte at the internal word pointer. A random read first sends a write-mode device address and one word byte to set the pointer, then a repeated start and a read-mode device address. A sequential burst follows either of these and keeps going for as long as the master acknowledges each byte.

Both bus lines are oversampled by the fast system clock through multi-flop synchronizers and turned into start, stop, rising-clock and falling-clock events. The data line is never driven high. The block only asserts a pull-low enable and reads the wired value back. The pointer advances after every byte sent, passes through the whole array, and wraps from the top location back to zero. The array contents come in through a plain preload port on the system clock.

Top module: `twi_seqrd_slave`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Both are judged on the synchronized lines.
- R2: A start seen at any point abandons the transfer in progress, releases the data line and begins a fresh device-address byte. A partly received word byte leaves the pointer unchanged.
- R3: The first byte after a start holds the 7-bit device address (default 0x50) in bits 7..1, received MSB first, and bit 0 selects read (1) or write (0). A match is acknowledged by holding the data line low through the ninth clock. On a mismatch the line stays released until the next start.
- R4: After a write-mode match, bits 6..0 of the next byte load the word pointer (bit 7 is ignored) and the byte is acknowledged. Any further byte in that access is not acknowledged.
- R5: A read-mode access returns first the byte at the word pointer, so a read without a preceding pointer load continues from where the last access left off.
- R6: Read data leaves MSB first. The slave changes its data-line drive only while the clock line is low.
- R7: Every byte sent advances the pointer by one. When the master acknowledges on the ninth clock, the next byte comes from the next ascending address.
- R8: The pointer covers all 128 locations and wraps from address 127 to address 0 during a burst.
- R9: A no-acknowledge (data line high on the ninth clock) ends the burst. The slave releases the line, ignores further clocks until a start, and keeps the pointer one past the last byte sent.
- R10: Reset leaves the data line released and the pointer at 0. While the preload enable is high, each system clock writes the preload data into the addressed location.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| sda_oe | output | 1 | Pull data line low when 1, release when 0 |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 7 | Preload location |
| pre_data | input | 8 | Preload byte |

## Verification
The bench goes after the wrap from 127 to 0 in a 130-byte burst. A pointer that stops at the top or skips a location returns wrong bytes there. After a no-acknowledge it keeps clocking without a stop and expects to read all ones. A slave that keeps transmitting would pull bits low. A start sent in the middle of a word byte must leave the pointer where it was, so a slave that commits a partial byte reads back from the wrong place. Wrong device addresses and extra write-mode bytes must come back unacknowledged, and a read issued straight after reset must return location 0.

// File: rtl/twi_pkg.sv
package twi_pkg;

   // Decoded bus activity, one system-clock pulse per event
   typedef struct packed {
      logic start;   // data falls while clock high
      logic stop;    // data rises while clock high
      logic rise;    // clock line rising edge
      logic fall;    // clock line falling edge
      logic sda;     // synchronized data level
      logic scl;     // synchronized clock level
   } twi_evt_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_WORD,
      ST_WORD_ACK,
      ST_TX
   } twi_state_e;

endpackage

// File: rtl/twi_linesync.sv
module twi_linesync #(
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output twi_pkg::twi_evt_t ev
);
   localparam int NLINES = 2;   // index 1 = clock, 0 = data

   if (STAGES < 2) begin : g_bad_stages
      $error("twi_linesync: STAGES must be at least 2");
   end

   logic [NLINES-1:0] raw;
   logic [NLINES-1:0] synced;
   logic [NLINES-1:0] prev;

   assign raw = {scl_i, sda_i};

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign synced[g] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= synced;
   end

   always_comb begin
      ev.scl   = synced[1];
      ev.sda   = synced[0];
      ev.rise  = synced[1] & ~prev[1];
      ev.fall  = ~synced[1] & prev[1];
      ev.start = synced[1] & prev[1] & prev[0] & ~synced[0];
      ev.stop  = synced[1] & prev[1] & ~prev[0] & synced[0];
   end

   AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev.start, ev.stop, ev.rise, ev.fall})); // R1

endmodule

// File: rtl/twi_store.sv
module twi_store #(
   parameter int AW             = 7,
   parameter int DW             = 8,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("twi_store: AW out of range");
   end

   logic [DW-1:0] mem [DEPTH];

   if (CLEAR_ON_RESET) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
         end
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (wr_en) mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/twi_engine.sv
module twi_engine
   import twi_pkg::*;
#(
   parameter int            AW       = 7,
   parameter int            DW       = 8,
   parameter logic [DW-2:0] DEV_ADDR = 7'h50
) (
   input  logic          clk,
   input  logic          rst_n,
   input  twi_evt_t      ev,
   input  logic [DW-1:0] rd_data,
   output logic [AW-1:0] rd_addr,
   output logic          sda_oe
);
   localparam int CW      = $clog2(DW + 2);
   localparam int LAST_B  = DW;       // count after the last data bit
   localparam int ACK_B   = DW + 1;   // count after the ninth clock

   if (AW >= DW) begin : g_bad_ptr
      $error("twi_engine: pointer must fit in one word byte");
   end

   twi_state_e    state;
   logic [CW-1:0] cnt;
   logic [DW-1:0] sh;
   logic [AW-1:0] ptr;
   logic          rw;
   logic          ack_n;
   logic          oe_q;

   assign rd_addr = ptr;
   assign sda_oe  = oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         sh    <= '0;
         ptr   <= '0;
         rw    <= 1'b0;
         ack_n <= 1'b1;
         oe_q  <= 1'b0;
      end else if (ev.start) begin
         state <= ST_DEV;
         cnt   <= '0;
         oe_q  <= 1'b0;
      end else if (ev.stop) begin
         state <= ST_IDLE;
         cnt   <= '0;
         oe_q  <= 1'b0;
      end else if (ev.rise) begin
         case (state)
            ST_DEV, ST_WORD: begin
               if (cnt < CW'(LAST_B)) sh <= {sh[DW-2:0], ev.sda};
               cnt <= cnt + 1'b1;
            end
            ST_DEV_ACK, ST_WORD_ACK: cnt <= cnt + 1'b1;
            ST_TX: begin
               if (cnt == CW'(LAST_B)) ack_n <= ev.sda;
               cnt <= cnt + 1'b1;
            end
            default: ;
         endcase
      end else if (ev.fall) begin
         case (state)
            ST_DEV: begin
               if (cnt == CW'(LAST_B)) begin
                  if (sh[DW-1:1] == DEV_ADDR) begin
                     oe_q  <= 1'b1;
                     rw    <= sh[0];
                     state <= ST_DEV_ACK;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_DEV_ACK: begin
               if (cnt == CW'(ACK_B)) begin
                  cnt <= '0;
                  if (rw) begin
                     sh    <= rd_data;
                     oe_q  <= ~rd_data[DW-1];
                     ptr   <= ptr + 1'b1;
                     state <= ST_TX;
                  end else begin
                     oe_q  <= 1'b0;
                     state <= ST_WORD;
                  end
               end
            end
            ST_WORD: begin
               if (cnt == CW'(LAST_B)) begin
                  oe_q  <= 1'b1;
                  state <= ST_WORD_ACK;
               end
            end
            ST_WORD_ACK: begin
               if (cnt == CW'(ACK_B)) begin
                  cnt   <= '0;
                  oe_q  <= 1'b0;
                  ptr   <= sh[AW-1:0];
                  state <= ST_IDLE;
               end
            end
            ST_TX: begin
               if (cnt != '0 && cnt < CW'(LAST_B)) begin
                  sh   <= {sh[DW-2:0], 1'b0};
                  oe_q <= ~sh[DW-2];
               end else if (cnt == CW'(LAST_B)) begin
                  oe_q <= 1'b0;
               end else if (cnt == CW'(ACK_B)) begin
                  cnt <= '0;
                  if (!ack_n) begin
                     sh   <= rd_data;
                     oe_q <= ~rd_data[DW-1];
                     ptr  <= ptr + 1'b1;
                  end else begin
                     oe_q  <= 1'b0;
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   AST_START_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ev.start) |-> (state == ST_DEV && cnt == '0 && !oe_q)); // R2

   AST_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEV_ACK || state == ST_WORD_ACK) |-> oe_q); // R3

   AST_SDA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.scl && $past(ev.scl) && !$past(ev.start) && !$past(ev.stop))
         |-> $stable(oe_q)); // R6

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr != $past(ptr) && $past(state) != ST_WORD_ACK)
         |-> (AW'(ptr - $past(ptr)) == AW'(1))); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !oe_q); // R9

endmodule

// File: rtl/twi_seqrd_slave.sv
module twi_seqrd_slave #(
   parameter int           AW             = 7,
   parameter int           DW             = 8,
   parameter int           SYNC_STAGES    = 2,
   parameter bit           CLEAR_ON_RESET = 1'b1,
   parameter logic [6:0]   DEV_ADDR       = 7'h50
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_oe,
   input  logic          pre_we,
   input  logic [AW-1:0] pre_addr,
   input  logic [DW-1:0] pre_data
);
   if (DW != 8) begin : g_bad_dw
      $error("twi_seqrd_slave: bus bytes are 8 bits");
   end

   twi_pkg::twi_evt_t ev;
   logic [AW-1:0]     rd_addr;
   logic [DW-1:0]     rd_data;

   twi_linesync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .ev    (ev)
   );

   twi_store #(.AW(AW), .DW(DW), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (pre_we),
      .wr_addr (pre_addr),
      .wr_data (pre_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   twi_engine #(.AW(AW), .DW(DW), .DEV_ADDR(DEV_ADDR)) u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev      (ev),
      .rd_data (rd_data),
      .rd_addr (rd_addr),
      .sda_oe  (sda_oe)
   );

endmodule

// File: tb/twi_seqrd_slave_bench.sv
module twi_seqrd_slave_bench;
   localparam int         CLK_PERIOD = 10;
   localparam int         HALF       = 8;
   localparam logic [6:0] DEV        = 7'h50;

   typedef struct packed {
      logic       rnd;   // 1: random read, 0: current-address read
      logic [6:0] wa;
      logic [8:0] len;
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 7'h10, 9'd4},
      '{1'b0, 7'h00, 9'd2},
      '{1'b1, 7'h7E, 9'd4},
      '{1'b0, 7'h00, 9'd1},
      '{1'b1, 7'h7F, 9'd130},
      '{1'b1, 7'h05, 9'd3},
      '{1'b0, 7'h00, 9'd3}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe;
   logic       pre_we = 1'b0;
   logic [6:0] pre_addr = '0;
   logic [7:0] pre_data = '0;
   logic       sda_bus;
   logic [6:0] mptr = '0;
   int         n_vec = 0;
   int         n_bad = 0;

   assign sda_bus = sda_m & ~sda_oe;

   always #(CLK_PERIOD/2) clk = ~clk;

   twi_seqrd_slave u_twi_seqrd_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_bus),
      .sda_oe   (sda_oe),
      .pre_we   (pre_we),
      .pre_addr (pre_addr),
      .pre_data (pre_data)
   );

   function automatic logic [7:0] pat(input logic [6:0] a);
      return 8'({1'b0, a} * 8'd3 + 8'd17);
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(HALF);
      scl_m = 1'b1; tick(HALF);
      sda_m = 1'b0; tick(HALF);
      scl_m = 1'b0; tick(2);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(HALF);
      scl_m = 1'b1; tick(HALF);
      sda_m = 1'b1; tick(HALF);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 0; i < n; i++) begin
         sda_m = b[7-i]; tick(HALF);
         scl_m = 1'b1;   tick(HALF);
         scl_m = 1'b0;   tick(2);
      end
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      sda_m = 1'b1; tick(HALF);
      scl_m = 1'b1; tick(HALF/2);
      ack = sda_bus; tick(HALF/2);
      scl_m = 1'b0; tick(2);
   endtask

   task automatic rd_byte(input logic give_ack, output logic [7:0] d);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(HALF);
         scl_m = 1'b1; tick(HALF/2);
         d[i] = sda_bus; tick(HALF/2);
         scl_m = 1'b0;
      end
      tick(2);
      sda_m = give_ack ? 1'b0 : 1'b1; tick(HALF);
      scl_m = 1'b1; tick(HALF);
      scl_m = 1'b0; tick(2);
      sda_m = 1'b1;
   endtask

   task automatic read_burst(input logic rnd, input logic [6:0] wa,
                             input int len, input logic do_stop);
      logic       ack;
      logic [7:0] d;
      bus_start();
      if (rnd) begin
         wr_byte({DEV, 1'b0}, ack);
         chk("R1 start then R3 write-mode ack", {7'd0, ack}, 8'd0);
         wr_byte({1'b0, wa}, ack);
         chk("R4 word byte ack", {7'd0, ack}, 8'd0);
         mptr = wa;
         bus_start();
      end
      wr_byte({DEV, 1'b1}, ack);
      chk("R3 read-mode ack", {7'd0, ack}, 8'd0);
      for (int i = 0; i < len; i++) begin
         rd_byte(i != len - 1, d);
         if (i == 0)            chk("R5 R6 first byte", d, pat(mptr));
         else if (mptr == '0)   chk("R8 wrap to 0", d, pat(mptr));
         else                   chk("R7 next ascending byte", d, pat(mptr));
         mptr = mptr + 1'b1;
      end
      if (do_stop) bus_stop();
   endtask

   initial begin : main
      logic       ack;
      logic [7:0] d;
      tick(3);
      chk("R10 released in reset", {7'd0, sda_oe}, 8'd0);
      rst_n = 1'b1;
      tick(3);
      chk("R10 released after reset", {7'd0, sda_oe}, 8'd0);
      for (int a = 0; a < 128; a++) begin
         pre_we = 1'b1; pre_addr = 7'(a); pre_data = pat(7'(a));
         tick(1);
      end
      pre_we = 1'b0;
      tick(4);

      // R10: pointer starts at 0, so a plain read returns location 0
      read_burst(1'b0, 7'h00, 1, 1'b1);

      for (int v = 0; v < NVEC; v++)
         read_burst(VEC[v].rnd, VEC[v].wa, int'(VEC[v].len), 1'b1);

      // R3: foreign device address gets no ack and no data
      bus_start();
      wr_byte({DEV ^ 7'h01, 1'b1}, ack);
      chk("R3 mismatch not acked", {7'd0, ack}, 8'd1);
      rd_byte(1'b0, d);
      chk("R3 mismatch line released", d, 8'hFF);
      bus_stop();

      // R9: after no-ack, clocks are ignored and pointer is kept
      read_burst(1'b1, 7'h40, 1, 1'b0);
      rd_byte(1'b0, d);
      chk("R9 silent after no-ack", d, 8'hFF);
      bus_stop();
      read_burst(1'b0, 7'h00, 1, 1'b1);

      // R2: start inside the word byte aborts; pointer unchanged
      bus_start();
      wr_byte({DEV, 1'b0}, ack);
      chk("R2 write-mode ack before abort", {7'd0, ack}, 8'd0);
      send_bits(8'h05, 3);
      bus_start();
      wr_byte({DEV, 1'b1}, ack);
      chk("R2 ack after aborting start", {7'd0, ack}, 8'd0);
      rd_byte(1'b0, d);
      chk("R2 pointer untouched by partial byte", d, pat(mptr));
      mptr = mptr + 1'b1;
      bus_stop();

      // R4: extra write-mode byte not acked, bit 7 of word byte ignored
      bus_start();
      wr_byte({DEV, 1'b0}, ack);
      wr_byte(8'hA0, ack);
      chk("R4 word byte acked", {7'd0, ack}, 8'd0);
      mptr = 7'h20;
      wr_byte(8'h99, ack);
      chk("R4 extra byte not acked", {7'd0, ack}, 8'd1);
      bus_stop();
      read_burst(1'b0, 7'h00, 2, 1'b1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule